// File: doc/BRIEF.md
# Tightly Coupled Memory Router

The router sits on the load/store port of a processor core and steers each access to one of three places: a scratchpad that holds instructions, a scratchpad that holds data, or the external bus. Both scratchpads are local RAM arrays inside the block. The data scratchpad window can be moved and resized while the core runs. Its base and its power-of-two size come from a region register, and a bit in a control register switches the window on or off. The instruction scratchpad always starts at address zero. Its length comes from its own region register and is switched by a second control bit.

Each access is aligned to its size. The aligned address is then tested against the instruction window first and the data window second. On a hit the block reads or writes the addressed bytes of the local RAM. If the window is larger than the physical array, the index wraps so the array repeats across the window. The block also reports the cycle count of the access. When neither window hits, the access leaves on a miss strobe with its aligned address and its other fields unchanged. The response, whether a hit or a miss, appears one clock after the request.

Top module: `tcm_router`

## Requirements
- R1: After reset no address hits either scratchpad (data base all ones, data size 0, instruction size 0), both RAMs read as zero, and the cycle count is 0.
- R2: With control bit 16 set, the data window base is the data region register with bits [11:0] cleared, and the size is 0x200 shifted left by region bits [5:1]. The window covers base <= addr < base + size.
- R3: With control bit 16 clear, no address hits the data scratchpad, and the RAM keeps its contents.
- R4: With control bit 18 set, the instruction window covers 0 <= addr < (0x200 shifted left by instruction region bits [5:1]). With the bit clear, the size is 0.
- R5: When both windows contain an address, the instruction scratchpad serves it and the data hit flag stays low.
- R6: The data RAM byte index is (addr - base) modulo DTCM_BYTES, so a window larger than the RAM repeats it.
- R7: The instruction RAM byte index is addr modulo ITCM_BYTES, so a window larger than the RAM repeats it.
- R8: Size codes are 0 = byte, 1 = halfword, 2 = word. Halfword accesses clear address bit 0, and word accesses clear bits [1:0], before decode.
- R9: Lanes are little-endian. Read data is returned right-aligned and zero-extended. Write data is taken right-aligned, and only the addressed bytes of the RAM word change.
- R10: A TCM hit that is not a sequential word access sets the cycle count to 1. A sequential word hit adds 1 to it. A miss leaves it unchanged.
- R11: Configuration writes select a register with cfg_sel: 0 = control, 1 = data region, 2 = instruction region. An access in the same cycle as a configuration write decodes with the old windows.
- R12: Every request gets rsp_valid one cycle later. On a miss, miss_valid rises in that same cycle with the aligned address, size, write flag and write data, and rsp_rdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_sel | input | 2 | Configuration register select |
| cfg_wdata | input | ADDR_W | Configuration write value |
| req_valid | input | 1 | Access request |
| req_we | input | 1 | Access is a write |
| req_seq | input | 1 | Access is sequential to the previous one |
| req_size | input | 2 | Access size code |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Right-aligned write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_itcm_hit | output | 1 | Instruction scratchpad served the access |
| rsp_dtcm_hit | output | 1 | Data scratchpad served the access |
| rsp_rdata | output | 32 | Right-aligned read data |
| rsp_cycles | output | CYC_W | Running access cycle count |
| miss_valid | output | 1 | Access forwarded to the external bus |
| miss_we | output | 1 | Forwarded write flag |
| miss_size | output | 2 | Forwarded size code |
| miss_addr | output | ADDR_W | Forwarded aligned address |
| miss_wdata | output | 32 | Forwarded write data |

## Verification
The bench probes both edges of each window: the last word inside and the first word outside. A design with an off-by-one or inclusive limit would hit one word too many or too few. It reads back through wrapped addresses, which a design that failed to mask the index would send out of range or to the bus. It overlaps the two windows, where a design with the wrong priority would return data-side contents. It writes configuration in the same cycle as an access, which a design that decoded with the new window would turn into a miss. It also runs sequential and non-sequential words, bytes and misses against the cycle count, and runs sub-word writes and unaligned halfword and word reads. These catch wrong lane placement and missing alignment.

// File: rtl/tcm_pkg.sv
package tcm_pkg;
  localparam int BUS_W      = 32;
  localparam int LANES      = BUS_W / 8;
  localparam int MIN_WIN    = 512;
  localparam int FIELD_LO   = 1;
  localparam int FIELD_W    = 5;
  localparam int BASE_CLR   = 12;
  localparam int DTCM_EN_BIT = 16;
  localparam int ITCM_EN_BIT = 18;

  typedef enum logic [1:0] {
    ACC_BYTE = 2'd0,
    ACC_HALF = 2'd1,
    ACC_WORD = 2'd2
  } acc_size_e;

  localparam logic [1:0] SEL_CTRL    = 2'd0;
  localparam logic [1:0] SEL_DREGION = 2'd1;
  localparam logic [1:0] SEL_IREGION = 2'd2;
endpackage

// File: rtl/tcm_window_regs.sv
module tcm_window_regs
  import tcm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LIM_W  = ADDR_W + 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [LIM_W-1:0]  dbase,
  output logic [LIM_W-1:0]  dsize,
  output logic [LIM_W-1:0]  isize
);
  logic [ADDR_W-1:0] ctrl_q, ctrl_n;
  logic [ADDR_W-1:0] dreg_q, dreg_n;
  logic [ADDR_W-1:0] ireg_q, ireg_n;
  logic [LIM_W-1:0]  dbase_q, dbase_n;
  logic [LIM_W-1:0]  dsize_q, dsize_n;
  logic [LIM_W-1:0]  isize_q, isize_n;
  logic              regs_en;
  logic              win_en;
  logic [FIELD_W-1:0] dfield, ifield;

  always_comb begin
    ctrl_n  = ctrl_q;
    dreg_n  = dreg_q;
    ireg_n  = ireg_q;
    regs_en = cfg_we;
    if (cfg_we) begin
      case (cfg_sel)
        SEL_CTRL:    ctrl_n = cfg_wdata;
        SEL_DREGION: dreg_n = cfg_wdata;
        SEL_IREGION: ireg_n = cfg_wdata;
        default:     regs_en = 1'b0;
      endcase
    end
    dfield = dreg_n[FIELD_LO +: FIELD_W];
    ifield = ireg_n[FIELD_LO +: FIELD_W];
    if (ctrl_n[DTCM_EN_BIT]) begin
      dbase_n = LIM_W'({dreg_n[ADDR_W-1:BASE_CLR], {BASE_CLR{1'b0}}});
      dsize_n = LIM_W'(MIN_WIN) << dfield;
    end else begin
      dbase_n = LIM_W'({ADDR_W{1'b1}});
      dsize_n = '0;
    end
    if (ctrl_n[ITCM_EN_BIT]) begin
      isize_n = LIM_W'(MIN_WIN) << ifield;
    end else begin
      isize_n = '0;
    end
    win_en = (dbase_n != dbase_q) || (dsize_n != dsize_q) || (isize_n != isize_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      dreg_q <= '0;
      ireg_q <= '0;
    end else if (regs_en) begin
      ctrl_q <= ctrl_n;
      dreg_q <= dreg_n;
      ireg_q <= ireg_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dbase_q <= LIM_W'({ADDR_W{1'b1}});
      dsize_q <= '0;
      isize_q <= '0;
    end else if (win_en) begin
      dbase_q <= dbase_n;
      dsize_q <= dsize_n;
      isize_q <= isize_n;
    end
  end

  assign dbase = dbase_q;
  assign dsize = dsize_q;
  assign isize = isize_q;
endmodule

// File: rtl/tcm_decode.sv
module tcm_decode
  import tcm_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LIM_W      = ADDR_W + 32,
  parameter int ITCM_BYTES = 1024,
  parameter int DTCM_BYTES = 512,
  localparam int IT_AW     = $clog2(ITCM_BYTES),
  localparam int DT_AW     = $clog2(DTCM_BYTES)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic [LIM_W-1:0]  dbase,
  input  logic [LIM_W-1:0]  dsize,
  input  logic [LIM_W-1:0]  isize,
  output logic [ADDR_W-1:0] aligned,
  output logic              itcm_hit,
  output logic              dtcm_hit,
  output logic [IT_AW-3:0]  itcm_widx,
  output logic [DT_AW-3:0]  dtcm_widx,
  output logic [1:0]        lane,
  output logic [LANES-1:0]  be
);
  logic [LIM_W-1:0]  addr_w;
  logic [LIM_W-1:0]  dlimit;
  logic [ADDR_W-1:0] doff;
  logic              in_dwin;

  always_comb begin
    case (acc_size_e'(size))
      ACC_BYTE: begin
        aligned = addr;
        be      = LANES'(1) << addr[1:0];
      end
      ACC_HALF: begin
        aligned = {addr[ADDR_W-1:1], 1'b0};
        be      = LANES'(3) << {addr[1], 1'b0};
      end
      default: begin
        aligned = {addr[ADDR_W-1:2], 2'b00};
        be      = '1;
      end
    endcase
    lane    = aligned[1:0];
    addr_w  = LIM_W'(aligned);
    dlimit  = dbase + dsize;
    in_dwin = (addr_w >= dbase) && (addr_w < dlimit);
    itcm_hit = addr_w < isize;
    dtcm_hit = in_dwin && !itcm_hit;
    doff     = aligned - dbase[ADDR_W-1:0];
    itcm_widx = aligned[IT_AW-1:2];
    dtcm_widx = doff[DT_AW-1:2];
  end
endmodule

// File: rtl/tcm_ram.sv
module tcm_ram
  import tcm_pkg::*;
#(
  parameter int BYTES = 512,
  localparam int WORDS = BYTES / LANES,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [LANES-1:0] be,
  input  logic [IDX_W-1:0] idx,
  input  logic [BUS_W-1:0] wword,
  output logic [BUS_W-1:0] rword
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] arr [WORDS];
    logic       lane_en;

    assign lane_en = we && be[l];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int w = 0; w < WORDS; w++) begin
          arr[w] <= '0;
        end
      end else if (lane_en) begin
        arr[idx] <= wword[l*8 +: 8];
      end
    end

    assign rword[l*8 +: 8] = arr[idx];
  end
endmodule

// File: rtl/tcm_router.sv
module tcm_router
  import tcm_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int ITCM_BYTES = 1024,
  parameter int DTCM_BYTES = 512,
  parameter int CYC_W      = 8,
  localparam int LIM_W     = ADDR_W + 32,
  localparam int IT_AW     = $clog2(ITCM_BYTES),
  localparam int DT_AW     = $clog2(DTCM_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic              req_seq,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic              rsp_itcm_hit,
  output logic              rsp_dtcm_hit,
  output logic [31:0]       rsp_rdata,
  output logic [CYC_W-1:0]  rsp_cycles,
  output logic              miss_valid,
  output logic              miss_we,
  output logic [1:0]        miss_size,
  output logic [ADDR_W-1:0] miss_addr,
  output logic [31:0]       miss_wdata
);
  logic [LIM_W-1:0]  dbase, dsize, isize;
  logic [ADDR_W-1:0] aligned;
  logic              itcm_hit, dtcm_hit, any_hit;
  logic [IT_AW-3:0]  itcm_widx;
  logic [DT_AW-3:0]  dtcm_widx;
  logic [1:0]        lane;
  logic [LANES-1:0]  be;
  logic [BUS_W-1:0]  wword, itcm_rword, dtcm_rword, sel_word, shifted;
  logic              itcm_we, dtcm_we;

  logic              valid_q, valid_n;
  logic              ihit_q, ihit_n;
  logic              dhit_q, dhit_n;
  logic [BUS_W-1:0]  rdata_q, rdata_n;
  logic [CYC_W-1:0]  cyc_q, cyc_n;
  logic              cyc_en;
  logic              mvalid_q, mvalid_n;
  logic              mwe_q;
  logic [1:0]        msize_q;
  logic [ADDR_W-1:0] maddr_q;
  logic [BUS_W-1:0]  mwdata_q;
  logic              mfields_en;

  tcm_window_regs #(.ADDR_W(ADDR_W), .LIM_W(LIM_W)) u_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .dbase     (dbase),
    .dsize     (dsize),
    .isize     (isize)
  );

  tcm_decode #(
    .ADDR_W(ADDR_W), .LIM_W(LIM_W),
    .ITCM_BYTES(ITCM_BYTES), .DTCM_BYTES(DTCM_BYTES)
  ) u_dec (
    .addr      (req_addr),
    .size      (req_size),
    .dbase     (dbase),
    .dsize     (dsize),
    .isize     (isize),
    .aligned   (aligned),
    .itcm_hit  (itcm_hit),
    .dtcm_hit  (dtcm_hit),
    .itcm_widx (itcm_widx),
    .dtcm_widx (dtcm_widx),
    .lane      (lane),
    .be        (be)
  );

  assign wword   = req_wdata << {lane, 3'b000};
  assign itcm_we = req_valid && req_we && itcm_hit;
  assign dtcm_we = req_valid && req_we && dtcm_hit;

  tcm_ram #(.BYTES(ITCM_BYTES)) u_itcm (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (itcm_we),
    .be    (be),
    .idx   (itcm_widx),
    .wword (wword),
    .rword (itcm_rword)
  );

  tcm_ram #(.BYTES(DTCM_BYTES)) u_dtcm (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (dtcm_we),
    .be    (be),
    .idx   (dtcm_widx),
    .wword (wword),
    .rword (dtcm_rword)
  );

  always_comb begin
    any_hit  = itcm_hit || dtcm_hit;
    sel_word = itcm_hit ? itcm_rword : (dtcm_hit ? dtcm_rword : '0);
    shifted  = sel_word >> {lane, 3'b000};
    valid_n  = req_valid;
    ihit_n   = req_valid && itcm_hit;
    dhit_n   = req_valid && dtcm_hit;
    mvalid_n = req_valid && !any_hit;
    rdata_n  = '0;
    if (req_valid && any_hit && !req_we) begin
      case (acc_size_e'(req_size))
        ACC_BYTE: rdata_n = {24'd0, shifted[7:0]};
        ACC_HALF: rdata_n = {16'd0, shifted[15:0]};
        default:  rdata_n = shifted;
      endcase
    end
    cyc_en = req_valid && any_hit;
    if (req_seq && (acc_size_e'(req_size) == ACC_WORD)) begin
      cyc_n = cyc_q + CYC_W'(1);
    end else begin
      cyc_n = CYC_W'(1);
    end
    mfields_en = mvalid_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      ihit_q   <= 1'b0;
      dhit_q   <= 1'b0;
      mvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      valid_q  <= valid_n;
      ihit_q   <= ihit_n;
      dhit_q   <= dhit_n;
      mvalid_q <= mvalid_n;
      rdata_q  <= rdata_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= '0;
    end else if (cyc_en) begin
      cyc_q <= cyc_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mwe_q    <= 1'b0;
      msize_q  <= '0;
      maddr_q  <= '0;
      mwdata_q <= '0;
    end else if (mfields_en) begin
      mwe_q    <= req_we;
      msize_q  <= req_size;
      maddr_q  <= aligned;
      mwdata_q <= req_wdata;
    end
  end

  assign rsp_valid    = valid_q;
  assign rsp_itcm_hit = ihit_q;
  assign rsp_dtcm_hit = dhit_q;
  assign rsp_rdata    = rdata_q;
  assign rsp_cycles   = cyc_q;
  assign miss_valid   = mvalid_q;
  assign miss_we      = mwe_q;
  assign miss_size    = msize_q;
  assign miss_addr    = maddr_q;
  assign miss_wdata   = mwdata_q;
endmodule

// File: rtl/tcm_router_chk.sv
module tcm_router_chk #(
  parameter int ADDR_W = 32,
  parameter int CYC_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_seq,
  input logic [1:0]        req_size,
  input logic              rsp_valid,
  input logic              rsp_itcm_hit,
  input logic              rsp_dtcm_hit,
  input logic [31:0]       rsp_rdata,
  input logic [CYC_W-1:0]  rsp_cycles,
  input logic              miss_valid,
  input logic [1:0]        miss_size,
  input logic [ADDR_W-1:0] miss_addr
);
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_itcm_hit && rsp_dtcm_hit)); // R5
  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R12
  AST_MISS_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid |-> (rsp_valid && !rsp_itcm_hit && !rsp_dtcm_hit)); // R12
  AST_MISS_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid |-> (rsp_rdata == 32'd0)); // R12
  AST_HALF_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && miss_size == 2'd1) |-> !miss_addr[0]); // R8
  AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && miss_size == 2'd2) |-> (miss_addr[1:0] == 2'b00)); // R8
  AST_NONSEQ_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !(req_seq && req_size == 2'd2)) |=>
      (!(rsp_itcm_hit || rsp_dtcm_hit) || rsp_cycles == CYC_W'(1))); // R10
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_seq && req_size == 2'd2) |=>
      (!(rsp_itcm_hit || rsp_dtcm_hit) || rsp_cycles == CYC_W'($past(rsp_cycles) + 1'b1))); // R10
  AST_MISS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (!miss_valid || $stable(rsp_cycles))); // R10
endmodule

bind tcm_router tcm_router_chk #(.ADDR_W(ADDR_W), .CYC_W(CYC_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_seq      (req_seq),
  .req_size     (req_size),
  .rsp_valid    (rsp_valid),
  .rsp_itcm_hit (rsp_itcm_hit),
  .rsp_dtcm_hit (rsp_dtcm_hit),
  .rsp_rdata    (rsp_rdata),
  .rsp_cycles   (rsp_cycles),
  .miss_valid   (miss_valid),
  .miss_size    (miss_size),
  .miss_addr    (miss_addr)
);

// File: tb/tcm_router_test.sv
module tcm_router_test;
  localparam int ADDR_W = 32;
  localparam int CYC_W  = 8;

  logic              clk;
  logic              rst_n;
  logic              cfg_we;
  logic [1:0]        cfg_sel;
  logic [ADDR_W-1:0] cfg_wdata;
  logic              req_valid, req_we, req_seq;
  logic [1:0]        req_size;
  logic [ADDR_W-1:0] req_addr;
  logic [31:0]       req_wdata;
  logic              rsp_valid, rsp_itcm_hit, rsp_dtcm_hit;
  logic [31:0]       rsp_rdata;
  logic [CYC_W-1:0]  rsp_cycles;
  logic              miss_valid, miss_we;
  logic [1:0]        miss_size;
  logic [ADDR_W-1:0] miss_addr;
  logic [31:0]       miss_wdata;

  int checks;
  int errors;
  bit done;

  localparam logic [31:0] CTRL_D = 32'h1 << 16;
  localparam logic [31:0] CTRL_I = 32'h1 << 18;

  tcm_router #(.ADDR_W(ADDR_W), .ITCM_BYTES(1024), .DTCM_BYTES(512), .CYC_W(CYC_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_we(req_we), .req_seq(req_seq),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_itcm_hit(rsp_itcm_hit), .rsp_dtcm_hit(rsp_dtcm_hit),
    .rsp_rdata(rsp_rdata), .rsp_cycles(rsp_cycles),
    .miss_valid(miss_valid), .miss_we(miss_we), .miss_size(miss_size),
    .miss_addr(miss_addr), .miss_wdata(miss_wdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // called at a negedge, returns at the next negedge with the response visible
  task automatic cfg(input logic [1:0] sel, input logic [31:0] val);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic acc(input logic we, input logic [1:0] sz, input logic seq,
                     input logic [31:0] addr, input logic [31:0] wd);
    req_valid = 1'b1; req_we = we; req_size = sz; req_seq = seq;
    req_addr = addr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0; req_seq = 1'b0;
  endtask

  // read and check: expected target 0 = miss, 1 = instruction, 2 = data
  task automatic rd(input string req, input logic [1:0] sz, input logic [31:0] addr,
                    input int tgt, input logic [31:0] exp);
    acc(1'b0, sz, 1'b0, addr, 32'd0);
    check(req, {29'd0, miss_valid, rsp_dtcm_hit, rsp_itcm_hit},
          {29'd0, tgt == 0, tgt == 2, tgt == 1});
    check(req, rsp_rdata, exp);
  endtask

  task automatic t_reset();
    check("R1 cycles", 32'(rsp_cycles), 32'd0);
    rd("R1 addr0", 2'd2, 32'h0, 0, 32'd0);
    rd("R1 ffff", 2'd2, 32'hFFFF_FFFC, 0, 32'd0);
    check("R12 rsp_valid", {31'd0, rsp_valid}, 32'd1);
    cfg(2'd2, 32'h0);
    cfg(2'd0, CTRL_I);
    rd("R1 itcm clear", 2'd2, 32'h20, 1, 32'd0);
  endtask

  task automatic t_itcm();
    acc(1'b1, 2'd2, 1'b0, 32'h10, 32'h1122_3344);
    check("R4 write hit", {31'd0, rsp_itcm_hit}, 32'd1);
    rd("R4 readback", 2'd2, 32'h10, 1, 32'h1122_3344);
    rd("R4 last word", 2'd2, 32'h1FC, 1, 32'd0);
    rd("R4 limit", 2'd2, 32'h200, 0, 32'd0);
  endtask

  task automatic t_lanes();
    acc(1'b1, 2'd0, 1'b0, 32'h13, 32'h0000_00AA);
    rd("R9 byte write", 2'd2, 32'h10, 1, 32'hAA22_3344);
    rd("R8 half align", 2'd1, 32'h13, 1, 32'h0000_AA22);
    rd("R9 byte read", 2'd0, 32'h11, 1, 32'h0000_0033);
    acc(1'b1, 2'd1, 1'b0, 32'h15, 32'h0000_BEEF);
    rd("R9 half write", 2'd2, 32'h14, 1, 32'h0000_BEEF);
    rd("R8 word align", 2'd2, 32'h17, 1, 32'h0000_BEEF);
  endtask

  task automatic t_imirror();
    cfg(2'd2, 32'h4);
    rd("R7 mirror", 2'd2, 32'h410, 1, 32'hAA22_3344);
    rd("R4 wide limit", 2'd2, 32'h7FC, 1, 32'd0);
    rd("R4 wide out", 2'd2, 32'h800, 0, 32'd0);
  endtask

  task automatic t_dtcm();
    cfg(2'd1, 32'h3082);
    cfg(2'd0, CTRL_I | CTRL_D);
    acc(1'b1, 2'd2, 1'b0, 32'h3008, 32'hCAFE_F00D);
    check("R2 write hit", {31'd0, rsp_dtcm_hit}, 32'd1);
    rd("R6 mirror", 2'd2, 32'h3208, 2, 32'hCAFE_F00D);
    rd("R2 last word", 2'd2, 32'h33FC, 2, 32'd0);
    rd("R2 limit", 2'd2, 32'h3400, 0, 32'd0);
    rd("R2 below base", 2'd2, 32'h2FFC, 0, 32'd0);
  endtask

  task automatic t_disable();
    cfg(2'd0, CTRL_I);
    rd("R3 disabled", 2'd2, 32'h3008, 0, 32'd0);
    cfg(2'd0, CTRL_I | CTRL_D);
    rd("R3 retained", 2'd2, 32'h3008, 2, 32'hCAFE_F00D);
  endtask

  task automatic t_priority();
    cfg(2'd1, 32'h2);
    rd("R5 overlap", 2'd2, 32'h10, 1, 32'hAA22_3344);
    rd("R5 outside both", 2'd2, 32'h900, 0, 32'd0);
    cfg(2'd0, CTRL_D);
    rd("R5 data alone", 2'd2, 32'h10, 2, 32'd0);
    cfg(2'd0, CTRL_I | CTRL_D);
  endtask

  task automatic t_same_cycle();
    cfg(2'd1, 32'h3082);
    cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = CTRL_I;
    req_valid = 1'b1; req_we = 1'b0; req_size = 2'd2; req_seq = 1'b0; req_addr = 32'h3008;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    check("R11 old window", {31'd0, rsp_dtcm_hit}, 32'd1);
    check("R11 old data", rsp_rdata, 32'hCAFE_F00D);
    rd("R11 new window", 2'd2, 32'h3008, 0, 32'd0);
  endtask

  task automatic t_cycles();
    acc(1'b0, 2'd2, 1'b0, 32'h10, 32'd0);
    check("R10 nonseq", 32'(rsp_cycles), 32'd1);
    acc(1'b0, 2'd2, 1'b1, 32'h14, 32'd0);
    check("R10 seq 2", 32'(rsp_cycles), 32'd2);
    acc(1'b0, 2'd2, 1'b1, 32'h18, 32'd0);
    check("R10 seq 3", 32'(rsp_cycles), 32'd3);
    acc(1'b0, 2'd2, 1'b1, 32'h9000, 32'd0);
    check("R10 miss hold", 32'(rsp_cycles), 32'd3);
    acc(1'b0, 2'd0, 1'b1, 32'h10, 32'd0);
    check("R10 seq byte", 32'(rsp_cycles), 32'd1);
  endtask

  task automatic t_miss();
    acc(1'b1, 2'd1, 1'b0, 32'h8003, 32'h0000_1234);
    check("R12 miss valid", {31'd0, miss_valid}, 32'd1);
    check("R12 miss addr", miss_addr, 32'h8002);
    check("R12 miss size", {30'd0, miss_size}, 32'd1);
    check("R12 miss we", {31'd0, miss_we}, 32'd1);
    check("R12 miss wdata", miss_wdata, 32'h0000_1234);
    check("R12 miss rdata", rsp_rdata, 32'd0);
    @(negedge clk);
    check("R12 idle", {30'd0, miss_valid, rsp_valid}, 32'd0);
  endtask

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0;
    cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    req_valid = 1'b0; req_we = 1'b0; req_seq = 1'b0;
    req_size = '0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_itcm();
    t_lanes();
    t_imirror();
    t_dtcm();
    t_disable();
    t_priority();
    t_same_cycle();
    t_cycles();
    t_miss();
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end
endmodule